// File: doc/BRIEF.md
# Early Depth-Stencil Test Unit

This block sits between a rasterizer and a fragment shading stage. Each accepted input beat carries a group of up to eight fragments. A fragment is a pixel, or one coverage sample when multisampling is on. Each fragment has a tile position, a sample index, a 24-bit depth value and an 8-bit stencil reference. The unit tests every valid fragment against a small on-chip depth/stencil store sized for one tile. It updates the store as the per-draw configuration directs. It returns a per-lane pass mask together with the unchanged fragment payloads. Fragments that fail the test have their pass bit cleared, so the next stage never shades them.

The configuration inputs are held stable for the length of a draw. They select:
- the depth compare function;
- whether depth is written;
- whether the stencil test is on, its mask, and the three stencil update operations;
- the sample count;
- a late-depth mode. In this mode every valid fragment is forwarded untested and the store is left alone, so a later stage can resolve visibility after shading.

A clear command fills every store location with a programmed depth and stencil value in a single cycle. No fragments are accepted in that cycle.

When several lanes of one group hit the same store location, they are resolved in lane order inside one cycle. Each lane sees the updates made by the lanes before it. The pass mask and payload appear one clock after acceptance.

Top module: `eds_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` is 0; `in_ready` is 1 once reset is low and no clear is requested.
- R2: A fragment passes the depth test when `frag_depth OP stored_depth` holds. OP is chosen by `cfg_depth_func`: 0 never, 1 less, 2 equal, 3 less-or-equal, 4 greater, 5 not-equal, 6 greater-or-equal, 7 always. Values are compared as unsigned.
- R3: A fragment that passes both tests writes its depth into the store only when `cfg_depth_write` is 1. Otherwise the stored depth is unchanged.
- R4: With `cfg_stencil_en` high, the stencil test passes when `(ref & cfg_stencil_mask) == (stored & cfg_stencil_mask)`. With it low, the stencil test always passes and the stored stencil is never changed. A lane passes only when both tests pass.
- R5: With the stencil test on, the stored stencil of every tested fragment is updated. The update is `cfg_op_sfail` when the stencil test fails, `cfg_op_zfail` when stencil passes and depth fails, and `cfg_op_zpass` when both pass. Op codes: 0 keep, 1 zero, 2 replace with ref, 3 increment saturating at 255, 4 decrement saturating at 0, 5 bitwise invert; 6 and 7 behave as keep.
- R6: A group is accepted when `in_valid` and `in_ready` are both 1. One cycle later `out_valid` is 1. `out_pass` bit i is 0 for every lane whose `in_lane_valid` bit was 0, and such lanes never touch the store. `out_x`, `out_y`, `out_sample`, `out_depth` and `out_sref` equal the accepted inputs.
- R7: Lanes of one group that address the same store location are resolved in ascending lane order. A later lane is tested against the value left by earlier lanes.
- R8: The store location is selected by `{y, x, s}`. The 2-bit sample field s depends on `cfg_msaa`: mode 0 (1x) uses s = 0, mode 1 (2x) uses `{0, sample[0]}`, and modes 2 and 3 (4x) use `sample[1:0]`. Sample bits outside the mode are ignored.
- R9: With `cfg_late_z` high, `out_pass` equals the lane-valid mask and the store is not modified.
- R10: A cycle with `clear_req` high writes `clear_depth` and `clear_stencil` into every store location, and `in_ready` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_depth_func | input | 3 | Depth compare function code |
| cfg_depth_write | input | 1 | Depth write enable |
| cfg_stencil_en | input | 1 | Stencil test enable |
| cfg_stencil_mask | input | 8 | Stencil compare mask |
| cfg_op_sfail | input | 3 | Stencil op on stencil fail |
| cfg_op_zfail | input | 3 | Stencil op on depth fail |
| cfg_op_zpass | input | 3 | Stencil op on full pass |
| cfg_late_z | input | 1 | Late-depth mode: forward untested |
| cfg_msaa | input | 2 | Samples per pixel: 0 = 1x, 1 = 2x, 2/3 = 4x |
| clear_req | input | 1 | Fill store with clear values this cycle |
| clear_depth | input | 24 | Clear depth value |
| clear_stencil | input | 8 | Clear stencil value |
| in_valid | input | 1 | Input group valid |
| in_ready | output | 1 | Unit can accept a group |
| in_lane_valid | input | LANES (8) | Per-lane valid mask |
| in_x | input | LANES×X_W (16) | Per-lane tile column |
| in_y | input | LANES×Y_W (16) | Per-lane tile row |
| in_sample | input | LANES×2 (16) | Per-lane sample index |
| in_depth | input | LANES×24 (192) | Per-lane fragment depth |
| in_sref | input | LANES×8 (64) | Per-lane stencil reference |
| out_valid | output | 1 | Output group valid |
| out_pass | output | LANES (8) | Per-lane survive mask |
| out_x | output | LANES×X_W (16) | Forwarded column |
| out_y | output | LANES×Y_W (16) | Forwarded row |
| out_sample | output | LANES×2 (16) | Forwarded sample index |
| out_depth | output | LANES×24 (192) | Forwarded depth |
| out_sref | output | LANES×8 (64) | Forwarded stencil reference |

## Verification
Directed groups come first.
- Lanes spread over distinct pixels show the depth function and write enable acting per lane.
- All eight lanes on one location with falling and then rising depths separate in-order resolution from any reordering or stale reads.
- Groups that differ only in sample index, under each sample mode, show whether out-of-mode sample bits are dropped.
- Stencil groups with masked references that match and miss exercise each outcome's operation.
- Late-mode groups followed by probe groups show that the store was left untouched.

Constrained random groups then crowd all lanes into a 2×2 pixel corner so that collisions are frequent. They draw every function, operation and mode, with sparse lane masks and an occasional clear. A reference model that keeps its own copy of the store checks every pass mask.

// File: rtl/eds_pkg.sv
`timescale 1ns/1ps
package eds_pkg;

    localparam int DEPTH_W = 24;
    localparam int STEN_W  = 8;
    localparam int SMP_W   = 2;

    typedef enum logic [2:0] {
        CMP_NEVER  = 3'd0,
        CMP_LT     = 3'd1,
        CMP_EQ     = 3'd2,
        CMP_LE     = 3'd3,
        CMP_GT     = 3'd4,
        CMP_NE     = 3'd5,
        CMP_GE     = 3'd6,
        CMP_ALWAYS = 3'd7
    } cmp_fn_e;

    typedef enum logic [2:0] {
        SOP_KEEP    = 3'd0,
        SOP_ZERO    = 3'd1,
        SOP_REPLACE = 3'd2,
        SOP_INC_SAT = 3'd3,
        SOP_DEC_SAT = 3'd4,
        SOP_INVERT  = 3'd5,
        SOP_RSVD6   = 3'd6,
        SOP_RSVD7   = 3'd7
    } sten_op_e;

    typedef struct packed {
        logic [DEPTH_W-1:0] depth;
        logic [STEN_W-1:0]  sten;
    } ds_word_t;

    typedef struct packed {
        cmp_fn_e            func;
        logic               depth_wr;
        logic               sten_en;
        logic [STEN_W-1:0]  sten_mask;
        sten_op_e           op_sfail;
        sten_op_e           op_zfail;
        sten_op_e           op_zpass;
        logic               late;
        logic [1:0]         msaa;
    } draw_cfg_t;

    function automatic logic depth_test(cmp_fn_e f, logic [DEPTH_W-1:0] frag,
                                        logic [DEPTH_W-1:0] stored);
        logic r;
        case (f)
            CMP_NEVER:  r = 1'b0;
            CMP_LT:     r = frag <  stored;
            CMP_EQ:     r = frag == stored;
            CMP_LE:     r = frag <= stored;
            CMP_GT:     r = frag >  stored;
            CMP_NE:     r = frag != stored;
            CMP_GE:     r = frag >= stored;
            default:    r = 1'b1;
        endcase
        return r;
    endfunction

    function automatic logic [STEN_W-1:0] sten_update(sten_op_e op,
                                                      logic [STEN_W-1:0] cur,
                                                      logic [STEN_W-1:0] ref_v);
        logic [STEN_W-1:0] r;
        case (op)
            SOP_ZERO:    r = '0;
            SOP_REPLACE: r = ref_v;
            SOP_INC_SAT: r = (&cur) ? cur : cur + 1'b1;
            SOP_DEC_SAT: r = (cur == '0) ? cur : cur - 1'b1;
            SOP_INVERT:  r = ~cur;
            default:     r = cur;
        endcase
        return r;
    endfunction

    function automatic logic [SMP_W-1:0] sample_slot(logic [1:0] msaa,
                                                     logic [SMP_W-1:0] s);
        logic [SMP_W-1:0] r;
        case (msaa)
            2'd0:    r = '0;
            2'd1:    r = {1'b0, s[0]};
            default: r = s;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/eds_store.sv
`timescale 1ns/1ps
module eds_store
    import eds_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  ds_word_t                     clr_word,
    input  logic [LANES-1:0]             wr_en,
    input  logic [LANES-1:0][ADDR_W-1:0] wr_addr,
    input  ds_word_t [LANES-1:0]         wr_data,
    input  logic [LANES-1:0][ADDR_W-1:0] rd_addr,
    output ds_word_t [LANES-1:0]         rd_data
);
    localparam int ENTRIES = 1 << ADDR_W;

    ds_word_t mem [ENTRIES];

    // Later lanes carry the newest value for a shared location, so the
    // highest-numbered writer wins.
    always_ff @(posedge clk) begin
        if (clr) begin
            for (int e = 0; e < ENTRIES; e++) mem[e] <= clr_word;
        end else begin
            for (int l = 0; l < LANES; l++)
                if (wr_en[l]) mem[wr_addr[l]] <= wr_data[l];
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_rd
        assign rd_data[g] = mem[rd_addr[g]];
    end

    AST_CLEAR_FILLS: assert property (@(posedge clk) disable iff (rst)
        clr |=> (mem[0] == $past(clr_word)) && (mem[ENTRIES-1] == $past(clr_word)));  // R10

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!clr && wr_en == '0) |=> $stable(mem[0]) && $stable(mem[ENTRIES-1]));  // R9

endmodule

// File: rtl/eds_resolve.sv
`timescale 1ns/1ps
module eds_resolve
    import eds_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int X_W    = 2,
    parameter int Y_W    = 2,
    parameter int ADDR_W = 6
) (
    input  draw_cfg_t                          cfg,
    input  logic [LANES-1:0]                   lane_valid,
    input  logic [LANES-1:0][X_W-1:0]          x,
    input  logic [LANES-1:0][Y_W-1:0]          y,
    input  logic [LANES-1:0][SMP_W-1:0]        smp,
    input  logic [LANES-1:0][DEPTH_W-1:0]      depth,
    input  logic [LANES-1:0][STEN_W-1:0]       sref,
    output logic [LANES-1:0][ADDR_W-1:0]       rd_addr,
    input  ds_word_t [LANES-1:0]               rd_data,
    output logic [LANES-1:0]                   pass,
    output logic [LANES-1:0]                   wr_en,
    output ds_word_t [LANES-1:0]               wr_data
);
    logic [LANES-1:0][ADDR_W-1:0] addr;

    for (genvar g = 0; g < LANES; g++) begin : g_addr
        assign addr[g] = {y[g], x[g], sample_slot(cfg.msaa, smp[g])};
    end
    assign rd_addr = addr;

    // Lanes are resolved in order; each sees the newest value from earlier lanes.
    always_comb begin
        ds_word_t cur;
        ds_word_t nxt;
        logic     sp;
        logic     dp;
        logic     act;
        pass    = '0;
        wr_en   = '0;
        wr_data = '0;
        for (int l = 0; l < LANES; l++) begin
            cur = rd_data[l];
            for (int j = 0; j < l; j++)
                if (wr_en[j] && addr[j] == addr[l]) cur = wr_data[j];
            sp  = !cfg.sten_en ||
                  ((sref[l] & cfg.sten_mask) == (cur.sten & cfg.sten_mask));
            dp  = depth_test(cfg.func, depth[l], cur.depth);
            act = lane_valid[l] && !cfg.late;
            nxt = cur;
            if (cfg.sten_en)
                nxt.sten = sten_update(sp ? (dp ? cfg.op_zpass : cfg.op_zfail)
                                          : cfg.op_sfail, cur.sten, sref[l]);
            if (sp && dp && cfg.depth_wr) nxt.depth = depth[l];
            wr_data[l] = nxt;
            wr_en[l]   = act && (cfg.sten_en || (cfg.depth_wr && sp && dp));
            pass[l]    = cfg.late ? lane_valid[l] : (act && sp && dp);
        end
    end

    always_comb begin
        AST_PASS_NEEDS_LANE: assert ((pass & ~lane_valid) == '0);  // R6
        AST_LATE_NO_WRITE: assert (!cfg.late || wr_en == '0);  // R9
    end

endmodule

// File: rtl/eds_top.sv
`timescale 1ns/1ps
module eds_top
    import eds_pkg::*;
#(
    parameter int LANES = 8,
    parameter int X_W   = 2,
    parameter int Y_W   = 2
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [2:0]                         cfg_depth_func,
    input  logic                               cfg_depth_write,
    input  logic                               cfg_stencil_en,
    input  logic [7:0]                         cfg_stencil_mask,
    input  logic [2:0]                         cfg_op_sfail,
    input  logic [2:0]                         cfg_op_zfail,
    input  logic [2:0]                         cfg_op_zpass,
    input  logic                               cfg_late_z,
    input  logic [1:0]                         cfg_msaa,
    input  logic                               clear_req,
    input  logic [23:0]                        clear_depth,
    input  logic [7:0]                         clear_stencil,
    input  logic                               in_valid,
    output logic                               in_ready,
    input  logic [LANES-1:0]                   in_lane_valid,
    input  logic [LANES-1:0][X_W-1:0]          in_x,
    input  logic [LANES-1:0][Y_W-1:0]          in_y,
    input  logic [LANES-1:0][1:0]              in_sample,
    input  logic [LANES-1:0][23:0]             in_depth,
    input  logic [LANES-1:0][7:0]              in_sref,
    output logic                               out_valid,
    output logic [LANES-1:0]                   out_pass,
    output logic [LANES-1:0][X_W-1:0]          out_x,
    output logic [LANES-1:0][Y_W-1:0]          out_y,
    output logic [LANES-1:0][1:0]              out_sample,
    output logic [LANES-1:0][23:0]             out_depth,
    output logic [LANES-1:0][7:0]              out_sref
);
    localparam int ADDR_W = Y_W + X_W + SMP_W;

    draw_cfg_t                    cfg;
    logic                         fire;
    logic [LANES-1:0][ADDR_W-1:0] rd_addr;
    ds_word_t [LANES-1:0]         rd_data;
    logic [LANES-1:0]             pass_c;
    logic [LANES-1:0]             we_c;
    ds_word_t [LANES-1:0]         wd_c;
    ds_word_t                     clr_word;

    assign cfg.func      = cmp_fn_e'(cfg_depth_func);
    assign cfg.depth_wr  = cfg_depth_write;
    assign cfg.sten_en   = cfg_stencil_en;
    assign cfg.sten_mask = cfg_stencil_mask;
    assign cfg.op_sfail  = sten_op_e'(cfg_op_sfail);
    assign cfg.op_zfail  = sten_op_e'(cfg_op_zfail);
    assign cfg.op_zpass  = sten_op_e'(cfg_op_zpass);
    assign cfg.late      = cfg_late_z;
    assign cfg.msaa      = cfg_msaa;

    assign clr_word.depth = clear_depth;
    assign clr_word.sten  = clear_stencil;

    assign in_ready = !rst && !clear_req;
    assign fire     = in_valid && in_ready;

    eds_resolve #(.LANES(LANES), .X_W(X_W), .Y_W(Y_W), .ADDR_W(ADDR_W)) u_resolve (
        .cfg        (cfg),
        .lane_valid (in_lane_valid),
        .x          (in_x),
        .y          (in_y),
        .smp        (in_sample),
        .depth      (in_depth),
        .sref       (in_sref),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .pass       (pass_c),
        .wr_en      (we_c),
        .wr_data    (wd_c)
    );

    eds_store #(.ADDR_W(ADDR_W), .LANES(LANES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .clr      (clear_req && !rst),
        .clr_word (clr_word),
        .wr_en    (we_c & {LANES{fire}}),
        .wr_addr  (rd_addr),
        .wr_data  (wd_c),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pass  <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                out_pass   <= pass_c;
                out_x      <= in_x;
                out_y      <= in_y;
                out_sample <= in_sample;
                out_depth  <= in_depth;
                out_sref   <= in_sref;
            end
        end
    end

    AST_FIRE_GIVES_OUT: assert property (@(posedge clk) disable iff (rst)
        fire |=> out_valid);  // R6

    AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !out_valid);  // R6

    AST_PASS_SUBSET: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_pass & ~$past(in_lane_valid)) == '0);  // R6

    AST_LATE_PASSES_ALL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(cfg_late_z)) |-> out_pass == $past(in_lane_valid));  // R9

    AST_PAYLOAD_KEPT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_depth == $past(in_depth) && out_sref == $past(in_sref));  // R6

endmodule

// File: tb/tb_eds_top.sv
`timescale 1ns/1ps
module tb_eds_top;

    localparam int L = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] cfg_depth_func = 3'd7;
    logic cfg_depth_write = 1'b0;
    logic cfg_stencil_en = 1'b0;
    logic [7:0] cfg_stencil_mask = 8'hFF;
    logic [2:0] cfg_op_sfail = 3'd0;
    logic [2:0] cfg_op_zfail = 3'd0;
    logic [2:0] cfg_op_zpass = 3'd0;
    logic cfg_late_z = 1'b0;
    logic [1:0] cfg_msaa = 2'd0;
    logic clear_req = 1'b0;
    logic [23:0] clear_depth = '0;
    logic [7:0] clear_stencil = '0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [L-1:0] in_lane_valid = '0;
    logic [L-1:0][1:0] in_x = '0;
    logic [L-1:0][1:0] in_y = '0;
    logic [L-1:0][1:0] in_sample = '0;
    logic [L-1:0][23:0] in_depth = '0;
    logic [L-1:0][7:0] in_sref = '0;
    logic out_valid;
    logic [L-1:0] out_pass;
    logic [L-1:0][1:0] out_x;
    logic [L-1:0][1:0] out_y;
    logic [L-1:0][1:0] out_sample;
    logic [L-1:0][23:0] out_depth;
    logic [L-1:0][7:0] out_sref;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [23:0] md [64];
    logic [7:0]  ms [64];

    always #2.5 clk = ~clk;

    eds_top dut (
        .clk(clk), .rst(rst),
        .cfg_depth_func(cfg_depth_func), .cfg_depth_write(cfg_depth_write),
        .cfg_stencil_en(cfg_stencil_en), .cfg_stencil_mask(cfg_stencil_mask),
        .cfg_op_sfail(cfg_op_sfail), .cfg_op_zfail(cfg_op_zfail),
        .cfg_op_zpass(cfg_op_zpass), .cfg_late_z(cfg_late_z), .cfg_msaa(cfg_msaa),
        .clear_req(clear_req), .clear_depth(clear_depth), .clear_stencil(clear_stencil),
        .in_valid(in_valid), .in_ready(in_ready), .in_lane_valid(in_lane_valid),
        .in_x(in_x), .in_y(in_y), .in_sample(in_sample), .in_depth(in_depth),
        .in_sref(in_sref), .out_valid(out_valid), .out_pass(out_pass),
        .out_x(out_x), .out_y(out_y), .out_sample(out_sample),
        .out_depth(out_depth), .out_sref(out_sref)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic int addr_of(int x, int y, int s, int m);
        int sm;
        sm = (m == 0) ? 0 : (m == 1) ? (s & 1) : (s & 3);
        return (y << 4) | (x << 2) | sm;
    endfunction

    function automatic bit m_depth(int f, logic [23:0] a, logic [23:0] b);
        case (f)
            0: return 0;
            1: return a < b;
            2: return a == b;
            3: return a <= b;
            4: return a > b;
            5: return a != b;
            6: return a >= b;
            default: return 1;
        endcase
    endfunction

    function automatic logic [7:0] m_sop(int op, logic [7:0] c, logic [7:0] r);
        case (op)
            1: return 8'h00;
            2: return r;
            3: return (c == 8'hFF) ? c : c + 8'd1;
            4: return (c == 8'h00) ? c : c - 8'd1;
            5: return ~c;
            default: return c;
        endcase
    endfunction

    task automatic model_group(output logic [L-1:0] e);
        e = '0;
        for (int l = 0; l < L; l++) begin
            if (in_lane_valid[l]) begin
                if (cfg_late_z) begin
                    e[l] = 1'b1;
                end else begin
                    int a;
                    bit sp, dp;
                    a  = addr_of(in_x[l], in_y[l], in_sample[l], cfg_msaa);
                    sp = !cfg_stencil_en ||
                         ((in_sref[l] & cfg_stencil_mask) == (ms[a] & cfg_stencil_mask));
                    dp = m_depth(cfg_depth_func, in_depth[l], md[a]);
                    if (cfg_stencil_en)
                        ms[a] = m_sop(sp ? (dp ? cfg_op_zpass : cfg_op_zfail) : cfg_op_sfail,
                                      ms[a], in_sref[l]);
                    if (sp && dp && cfg_depth_write) md[a] = in_depth[l];
                    e[l] = sp && dp;
                end
            end
        end
    endtask

    // Called just after a negedge; returns just after the next negedge.
    task automatic run_group(input string tag);
        logic [L-1:0] e;
        logic [L-1:0][23:0] dsent;
        model_group(e);
        dsent = in_depth;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, {tag, " out_valid"}, 32'(out_valid), 32'd1);
        chk(out_pass == e, {tag, " pass"}, 32'(out_pass), 32'(e));
        chk(out_depth == dsent, "R6 payload depth", out_depth[0], dsent[0]);
    endtask

    task automatic do_clear(input logic [23:0] d, input logic [7:0] s);
        clear_depth = d;
        clear_stencil = s;
        clear_req = 1'b1;
        #1;
        chk(in_ready == 1'b0, "R10 ready low in clear", 32'(in_ready), 32'd0);
        @(negedge clk);
        clear_req = 1'b0;
        for (int i = 0; i < 64; i++) begin
            md[i] = d;
            ms[i] = s;
        end
    endtask

    task automatic set_cfg(input int f, input bit dw, input bit se, input logic [7:0] sm,
                           input int osf, input int ozf, input int ozp, input bit late,
                           input int msaa);
        cfg_depth_func = 3'(f);
        cfg_depth_write = dw;
        cfg_stencil_en = se;
        cfg_stencil_mask = sm;
        cfg_op_sfail = 3'(osf);
        cfg_op_zfail = 3'(ozf);
        cfg_op_zpass = 3'(ozp);
        cfg_late_z = late;
        cfg_msaa = 2'(msaa);
    endtask

    task automatic spread_lanes();
        for (int l = 0; l < L; l++) begin
            in_x[l] = 2'(l % 4);
            in_y[l] = 2'(l / 4);
            in_sample[l] = 2'd0;
        end
    endtask

    initial begin
        #(200000 * 5);
        $display("FAIL watchdog expired actual=0 expected=1");
        errors++;
        checks++;
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", 32'(out_valid), 32'd0);
        rst = 1'b0;
        #1;
        chk(in_ready == 1'b1, "R1 ready after reset", 32'(in_ready), 32'd1);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid idle", 32'(out_valid), 32'd0);

        do_clear(24'h800000, 8'h10);

        // R2 / R3: distinct pixels, less with write
        set_cfg(1, 1, 0, 8'hFF, 0, 0, 0, 0, 0);
        spread_lanes();
        in_lane_valid = 8'hFF;
        for (int l = 0; l < L; l++) in_depth[l] = (l % 2 == 0) ? 24'h7FFFFF : 24'h800001;
        run_group("R2 less");
        set_cfg(2, 0, 0, 8'hFF, 0, 0, 0, 0, 0);
        for (int l = 0; l < L; l++) in_depth[l] = 24'h7FFFFF;
        run_group("R3 written depth probe");
        set_cfg(1, 0, 0, 8'hFF, 0, 0, 0, 0, 0);
        for (int l = 0; l < L; l++) in_depth[l] = 24'h000001;
        run_group("R3 write disabled");
        set_cfg(2, 0, 0, 8'hFF, 0, 0, 0, 0, 0);
        run_group("R3 unchanged probe");
        for (int f = 0; f < 8; f++) begin
            set_cfg(f, 0, 0, 8'hFF, 0, 0, 0, 0, 0);
            for (int l = 0; l < L; l++) in_depth[l] = 24'h7FFFFD + 24'(l);
            run_group("R2 func sweep");
        end

        // R6: sparse lane mask
        set_cfg(7, 1, 0, 8'hFF, 0, 0, 0, 0, 0);
        in_lane_valid = 8'hA5;
        for (int l = 0; l < L; l++) in_depth[l] = 24'h000100;
        run_group("R6 sparse mask");
        in_lane_valid = 8'hFF;
        set_cfg(2, 0, 0, 8'hFF, 0, 0, 0, 0, 0);
        run_group("R6 untouched lanes probe");

        // R7: all lanes on one location
        do_clear(24'h800000, 8'h00);
        in_x = '0; in_y = '0; in_sample = '0;
        set_cfg(1, 1, 0, 8'hFF, 0, 0, 0, 0, 0);
        for (int l = 0; l < L; l++) in_depth[l] = 24'd1000 - 24'(l * 10);
        run_group("R7 falling depths");
        for (int l = 0; l < L; l++) in_depth[l] = 24'd200 + 24'(l * 10);
        run_group("R7 rising depths");

        // R8: sample modes
        for (int m = 0; m < 3; m++) begin
            do_clear(24'h800000, 8'h00);
            set_cfg(1, 1, 0, 8'hFF, 0, 0, 0, 0, m);
            for (int l = 0; l < L; l++) begin
                in_x[l] = 2'd1; in_y[l] = 2'd2;
                in_sample[l] = 2'(l % 4);
                in_depth[l] = 24'd500 - 24'(l);
            end
            run_group("R8 msaa mode");
            for (int l = 0; l < L; l++) in_depth[l] = 24'd496;
            run_group("R8 msaa probe");
        end

        // R4 / R5: stencil
        do_clear(24'h800000, 8'h35);
        spread_lanes();
        for (int op = 0; op < 8; op++) begin
            set_cfg(3, 0, 1, 8'h0F, op, (op + 1) % 8, (op + 2) % 8, 0, 0);
            for (int l = 0; l < L; l++) begin
                in_sref[l] = (l < 4) ? 8'hA5 : 8'h53;
                in_depth[l] = (l % 2 == 1) ? 24'hFFFFFF : 24'h000010;
            end
            run_group("R5 stencil ops");
            set_cfg(7, 0, 1, 8'hFF, 0, 0, 0, 0, 0);
            for (int v = 0; v < 4; v++) begin
                for (int l = 0; l < L; l++) in_sref[l] = 8'($urandom % 256);
                run_group("R4 stencil probe");
            end
        end
        set_cfg(7, 0, 0, 8'hFF, 5, 5, 5, 0, 0);
        run_group("R4 stencil off");

        // R9: late mode leaves the store alone
        set_cfg(0, 1, 1, 8'hFF, 1, 1, 1, 1, 0);
        in_lane_valid = 8'h3C;
        run_group("R9 late pass all");
        in_lane_valid = 8'hFF;
        set_cfg(7, 0, 1, 8'hFF, 0, 0, 0, 0, 0);
        run_group("R9 late probe");

        // Random mix with frequent collisions
        for (int n = 0; n < 600; n++) begin
            if ($urandom % 40 == 0)
                do_clear(24'($urandom), 8'($urandom));
            set_cfg($urandom % 8, $urandom % 2, $urandom % 2, 8'($urandom),
                    $urandom % 8, $urandom % 8, $urandom % 8, ($urandom % 8) == 0,
                    $urandom % 4);
            in_lane_valid = 8'($urandom);
            for (int l = 0; l < L; l++) begin
                in_x[l] = 2'($urandom % 2);
                in_y[l] = 2'($urandom % 2);
                in_sample[l] = 2'($urandom);
                in_depth[l] = 24'h7FFFF0 + 24'($urandom % 32);
                in_sref[l] = 8'($urandom % 4) + 8'hFE;
            end
            run_group(cfg_late_z ? "R9 random late" : "R7 random");
        end

        @(negedge clk);
        chk(out_valid == 1'b0, "R6 idle after last group", 32'(out_valid), 32'd0);
        summary();
    end

endmodule